// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block turns the system clock into the timing strobes that one serial channel needs. The rate depends on three settings. An 8-bit divisor value N is written through a small register port. A 2-bit prescale select n divides the clock by 4^n. A mode select picks asynchronous, clocked synchronous or smart-card timing. Each channel has its own copy of the block.

Prescaler and divisor together give a terminal tick every 4^n × (N+1) system clocks. A half-rate stage halves that into a basic-clock strobe. A sequencer counts basic clocks into bit-boundary and mid-bit sample strobes. In synchronous mode it also drives a serial clock with 50% duty. In smart-card mode the number of basic clocks per bit is chosen from four values. Any write to the divisor, or a low enable, puts every counter back at phase zero.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset the divisor register reads 0xFF, basicTick, bitTick and sampleTick are low, and sclkOut is high.
- R2: rdData always shows the divisor register. A write (wrEn high at a clock edge) loads wrData, and rdData shows the new value from the next cycle.
- R3: While running, basicTick pulses for one cycle every 2 × 4^n × (N+1) clocks, with n = prescSel (00→1, 01→4, 10→16, 11→64 prescale). The first pulse appears 2 × 4^n × (N+1) cycles after the last restart edge.
- R4: In asynchronous mode (modeSel 00, and also 11), bitTick marks every 16th basic clock and sampleTick marks the 8th basic clock of each bit.
- R5: In synchronous mode (modeSel 01), sclkOut toggles on every basic clock and starts high. Each falling edge comes with bitTick and each rising edge comes with sampleTick, so one bit lasts 4 × 4^n × (N+1) clocks.
- R6: In smart-card mode (modeSel 10), cardSel picks S basic clocks per bit (00→32, 01→64, 10→372, 11→256). bitTick marks every S-th basic clock and sampleTick marks basic clock S/2 of each bit.
- R7: Outside synchronous mode, sclkOut stays high.
- R8: A divisor write restarts the prescaler, divisor, half-rate stage and basic counters. It clears the strobes in the next cycle, and the next basic pulse follows the R3 spacing counted from that write.
- R9: While enable is low, all counters are held at zero, every strobe is low and sclkOut is high.
- R10: bitTick and sampleTick only appear together with basicTick, and never together with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| enable | input | 1 | Run enable; low holds all counters cleared |
| modeSel | input | 2 | 00 async, 01 synchronous, 10 smart-card, 11 async |
| prescSel | input | 2 | Prescale exponent n (divide by 4^n) |
| cardSel | input | 2 | Smart-card basic clocks per bit |
| wrEn | input | 1 | Divisor register write strobe |
| wrData | input | 8 | Divisor write value |
| rdData | output | 8 | Current divisor register value |
| basicTick | output | 1 | Basic-clock strobe |
| bitTick | output | 1 | Bit-boundary strobe |
| sampleTick | output | 1 | Mid-bit sample strobe |
| sclkOut | output | 1 | Serial clock for synchronous mode |

## Verification
The serial-clock properties assume that modeSel is held steady while the channel runs. The checker therefore only ties sclkOut changes to basicTick when the mode was synchronous in both the previous and the current cycle. The bench changes mode, prescale and card selects only while enable is low, and it always follows a change with a divisor write. Every stimulus therefore starts from a restart, which matches how software is expected to reprogram a channel.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_CARD  = 2'b10,
    MODE_SPARE = 2'b11
  } srgMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;
    logic loadDiv;
  } srgCtrl_t;

  // basic clocks per bit in smart-card mode
  function automatic int unsigned cardBitLen(input logic [1:0] sel);
    case (sel)
      2'b00:   return 32;
      2'b01:   return 64;
      2'b10:   return 372;
      default: return 256;
    endcase
  endfunction

endpackage

// File: rtl/srg_divpath.sv
module srg_divpath
  import srg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2,
  parameter logic [DIV_W-1:0] RESET_DIV = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  srgCtrl_t         ctrl,
  input  logic [DIV_W-1:0] wrData,
  input  logic [PRE_W-1:0] prescSel,
  output logic [DIV_W-1:0] divValue,
  output logic             basicPulse
);

  // widest prescale is 4^(2^PRE_W - 1)
  localparam int PRE_CNT_W = 2 * ((1 << PRE_W) - 1);

  logic [DIV_W-1:0]     divReg;
  logic [DIV_W-1:0]     divCnt;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLimit;
  logic                 preTick;
  logic                 termTick;
  logic                 halfStage;

  // limit is 4^n - 1: the low 2n bits set
  always_comb begin
    for (int i = 0; i < PRE_CNT_W; i++) begin
      preLimit[i] = (i < 2 * int'(prescSel));
    end
  end

  assign preTick    = (preCnt == preLimit);
  assign termTick   = preTick && (divCnt == divReg);
  assign basicPulse = termTick && halfStage;
  assign divValue   = divReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= RESET_DIV;
    end else if (ctrl.loadDiv) begin
      divReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      divCnt    <= '0;
      halfStage <= 1'b0;
    end else if (ctrl.restart) begin
      preCnt    <= '0;
      divCnt    <= '0;
      halfStage <= 1'b0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (preTick) begin
        divCnt <= termTick ? '0 : divCnt + 1'b1;
      end
      if (termTick) begin
        halfStage <= ~halfStage;
      end
    end
  end

endmodule

// File: rtl/srg_sequencer.sv
module srg_sequencer
  import srg_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       wrEn,
  input  logic [1:0] modeSel,
  input  logic [1:0] cardSel,
  input  logic       basicPulse,
  output srgCtrl_t   ctrl,
  output logic       basicTick,
  output logic       bitTick,
  output logic       sampleTick,
  output logic       sclkOut
);

  srgMode_e         mode;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] periodLen;
  logic             wrapHit;
  logic             midHit;
  logic             sclkReg;

  assign mode         = srgMode_e'(modeSel);
  assign ctrl.restart = !enable || wrEn;
  assign ctrl.loadDiv = wrEn;

  assign periodLen = (mode == MODE_CARD) ? CNT_W'(cardBitLen(cardSel))
                                         : CNT_W'(OVERSAMPLE);
  assign nextCnt   = baseCnt + 1'b1;
  assign wrapHit   = (nextCnt == periodLen);
  assign midHit    = (nextCnt == (periodLen >> 1));
  assign sclkOut   = sclkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCnt    <= '0;
      basicTick  <= 1'b0;
      bitTick    <= 1'b0;
      sampleTick <= 1'b0;
      sclkReg    <= 1'b1;
    end else if (ctrl.restart) begin
      baseCnt    <= '0;
      basicTick  <= 1'b0;
      bitTick    <= 1'b0;
      sampleTick <= 1'b0;
      sclkReg    <= 1'b1;
    end else begin
      basicTick  <= basicPulse;
      bitTick    <= 1'b0;
      sampleTick <= 1'b0;
      if (mode == MODE_SYNC) begin
        if (basicPulse) begin
          bitTick    <= sclkReg;
          sampleTick <= !sclkReg;
          sclkReg    <= !sclkReg;
        end
      end else begin
        sclkReg <= 1'b1;
        if (basicPulse) begin
          baseCnt    <= wrapHit ? '0 : nextCnt;
          bitTick    <= wrapHit;
          sampleTick <= midHit;
        end
      end
    end
  end

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PRE_W      = 2,
  parameter int CNT_W      = 9,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       modeSel,
  input  logic [PRE_W-1:0] prescSel,
  input  logic [1:0]       cardSel,
  input  logic             wrEn,
  input  logic [DIV_W-1:0] wrData,
  output logic [DIV_W-1:0] rdData,
  output logic             basicTick,
  output logic             bitTick,
  output logic             sampleTick,
  output logic             sclkOut
);

  srgCtrl_t ctrl;
  logic     basicPulse;

  srg_divpath #(
    .DIV_W    (DIV_W),
    .PRE_W    (PRE_W),
    .RESET_DIV('1)
  ) u_divpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .prescSel  (prescSel),
    .divValue  (rdData),
    .basicPulse(basicPulse)
  );

  srg_sequencer #(
    .CNT_W     (CNT_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_sequencer (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .wrEn      (wrEn),
    .modeSel   (modeSel),
    .cardSel   (cardSel),
    .basicPulse(basicPulse),
    .ctrl      (ctrl),
    .basicTick (basicTick),
    .bitTick   (bitTick),
    .sampleTick(sampleTick),
    .sclkOut   (sclkOut)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [1:0]       modeSel,
  input logic             wrEn,
  input logic [DIV_W-1:0] wrData,
  input logic [DIV_W-1:0] rdData,
  input logic             basicTick,
  input logic             bitTick,
  input logic             sampleTick,
  input logic             sclkOut
);

  // R9
  strobes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!basicTick && !bitTick && !sampleTick));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !basicTick);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));

  // R10
  bit_on_basic_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> basicTick);

  // R10
  sample_on_basic_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> basicTick);

  // R10
  bit_sample_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bitTick && sampleTick));

  // R7
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b01) |=> sclkOut);

  // R5
  sclk_moves_on_basic_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !$past(wrEn) && (modeSel == 2'b01) &&
     ($past(modeSel) == 2'b01) && !$stable(sclkOut)) |-> basicTick);

endmodule

bind serial_rate_gen srg_checker #(.DIV_W(DIV_W)) u_srg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .modeSel   (modeSel),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .basicTick (basicTick),
  .bitTick   (bitTick),
  .sampleTick(sampleTick),
  .sclkOut   (sclkOut)
);

// File: tb/serial_rate_gen_test.sv
`timescale 1ns/1ps
module serial_rate_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [1:0] prescSel = 2'b00;
  logic [1:0] cardSel = 2'b00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       basicTick, bitTick, sampleTick, sclkOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit compareOn = 0;
  string curTag = "R1";

  // reference model state
  int  mDiv = 255;
  longint cnt = 0;
  longint k = 0;
  bit  eBasic = 0, eBit = 0, eSample = 0, eSclk = 1;

  always #4 clk = ~clk;

  serial_rate_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .cardSel(cardSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .basicTick(basicTick), .bitTick(bitTick),
    .sampleTick(sampleTick), .sclkOut(sclkOut)
  );

  function automatic int sPerBit(input logic [1:0] m, input logic [1:0] c);
    if (m != 2'b10) return 16;
    case (c)
      2'b00: return 32;
      2'b01: return 64;
      2'b10: return 372;
      default: return 256;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 255; cnt = 0; k = 0;
      eBasic = 0; eBit = 0; eSample = 0; eSclk = 1;
    end else if (!enable || wrEn) begin
      if (wrEn) mDiv = int'(wrData);
      cnt = 0; k = 0;
      eBasic = 0; eBit = 0; eSample = 0; eSclk = 1;
    end else begin
      longint p;
      bit tc;
      p  = longint'(4 ** int'(prescSel)) * longint'(mDiv + 1);
      tc = (cnt % (2 * p)) == (2 * p - 1);
      cnt++;
      eBasic = tc; eBit = 0; eSample = 0;
      if (modeSel == 2'b01) begin
        if (tc) begin
          k++;
          if (eSclk) eBit = 1; else eSample = 1;
          eSclk = !eSclk;
        end
      end else begin
        eSclk = 1;
        if (tc) begin
          int s;
          k++;
          s = sPerBit(modeSel, cardSel);
          eBit    = (k % s) == 0;
          eSample = (k % s) == s / 2;
        end
      end
    end
  end

  task automatic check1(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, curTag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn && !done) begin
      string seqReq;
      seqReq = !enable ? "R9" : (modeSel == 2'b01) ? "R5" : (modeSel == 2'b10) ? "R6" : "R4";
      check1("R2 rdData", int'(rdData), mDiv);
      check1("R3 basicTick", int'(basicTick), int'(eBasic));
      check1({seqReq, " bitTick"}, int'(bitTick), int'(eBit));
      check1({seqReq, " sampleTick"}, int'(sampleTick), int'(eSample));
      check1((modeSel == 2'b01) ? "R5 sclkOut" : "R7 sclkOut", int'(sclkOut), int'(eSclk));
    end
  end

  task automatic setup(input logic [1:0] m, input logic [1:0] n, input logic [1:0] c,
                       input logic [7:0] divN, input int cycles, input string tag);
    @(negedge clk);
    curTag = tag;
    enable = 0;
    @(negedge clk);
    modeSel = m; prescSel = n; cardSel = c;
    wrEn = 1; wrData = divN;
    @(negedge clk);
    wrEn = 0; enable = 1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    check1("R1 rdData", int'(rdData), 255);
    check1("R1 strobes", int'({basicTick, bitTick, sampleTick}), 0);
    check1("R1 sclkOut", int'(sclkOut), 1);
    compareOn = 1;

    setup(2'b00, 2'b00, 2'b00, 8'd2, 500, "R4");
    setup(2'b00, 2'b01, 2'b00, 8'd0, 600, "R3");
    setup(2'b11, 2'b11, 2'b00, 8'd0, 4200, "R4");
    setup(2'b01, 2'b00, 2'b00, 8'd1, 300, "R5");
    setup(2'b01, 2'b10, 2'b00, 8'd0, 400, "R5");
    setup(2'b10, 2'b00, 2'b00, 8'd0, 300, "R6");
    setup(2'b10, 2'b00, 2'b01, 8'd0, 600, "R6");
    setup(2'b10, 2'b00, 2'b10, 8'd0, 1600, "R6");
    setup(2'b10, 2'b00, 2'b11, 8'd1, 2200, "R6");
    setup(2'b10, 2'b01, 2'b00, 8'd0, 700, "R10");

    // R8: write in the middle of a run restarts the phase
    setup(2'b00, 2'b00, 2'b00, 8'd3, 37, "R8");
    wrEn = 1; wrData = 8'd1;
    @(negedge clk);
    wrEn = 0;
    repeat (300) @(negedge clk);

    // R9: enable low mid-run holds everything, then resume
    curTag = "R9";
    enable = 0;
    repeat (50) @(negedge clk);
    enable = 1;
    repeat (200) @(negedge clk);

    // R2: write while disabled, value still read back
    curTag = "R2";
    enable = 0;
    wrEn = 1; wrData = 8'hA5;
    @(negedge clk);
    wrEn = 0;
    repeat (5) @(negedge clk);
    check1("R2 readback", int'(rdData), 165);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule